// File: doc/BRIEF.md
# RAID-6 P/Q Syndrome Generator

This block produces the two redundancy words of a dual-parity disk stripe for one byte offset. It takes a stream of data words, one per data disk, that starts at the highest-numbered data disk and ends at disk 0. It returns the plain XOR parity word P and the Reed-Solomon syndrome word Q, both over GF(2^8) with the field polynomial 0x11D and generator 2. A stripe of N disks carries N-2 data disks, numbered 0 to N-3. The two redundancy slots follow them, P first and then Q.

Each word is a set of independent byte lanes, and the lane count is a parameter. Q is built by Horner's rule. The first word of a stripe loads both accumulators. Every later word doubles each Q byte in the field and then XORs in the data. After the final word, P and Q appear together on a registered output with a one-cycle valid pulse, and the accumulators go back to zero for the next offset.

Top module: `pq_syndrome_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low, `out_p` and `out_q` are zero, and `in_ready` is low. `in_ready` goes high on the first clock edge after reset is released and then stays high.
- R2: `out_p` equals the XOR of every data word accepted in the stripe.
- R3: `out_q` equals, lane by lane, the GF(2^8) sum of 2^z·D_z. Words arrive highest disk first, so the last word of the stripe is disk 0.
- R4: Field doubling shifts a byte left by one and XORs 0x1D when the byte's top bit was set. For example, 0x80 followed by 0x00 gives Q byte 0x1D, and 0x80 followed by two 0x00 words gives 0x3A.
- R5: Byte lane l occupies bits [8l+7:8l]. No lane's result depends on any other lane.
- R6: `out_valid` is high for exactly one cycle, in the cycle after a beat with `in_last` is accepted (`in_valid` and `in_ready` both high). It is low at all other times.
- R7: A stripe of a single beat with both `in_first` and `in_last` set gives `out_p` = `out_q` = that word.
- R8: After a stripe ends, both accumulators are zero. A following stripe that has no `in_first` flag therefore gives the same result as one that has it.
- R9: A beat with `in_first` discards any partial sums already gathered, and the stripe restarts from that word.
- R10: Cycles with `in_valid` low change nothing, whatever values `in_data`, `in_first` and `in_last` carry.
- R11: `out_p` and `out_q` hold their last values in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Data beat present |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 8*LANES | Data word for one disk |
| in_first | input | 1 | Beat is the highest data disk (restart) |
| in_last | input | 1 | Beat is data disk 0 (finish) |
| out_valid | output | 1 | P and Q valid for one cycle |
| out_p | output | 8*LANES | XOR parity word |
| out_q | output | 8*LANES | Reed-Solomon syndrome word |

## Verification
The bench targets the reduction step with bytes whose top bit is set, and alternates those bytes across lanes. A wrong constant or a missing reduction then corrupts Q, and a lane-indexing mistake mixes neighbouring results. A one-word stripe catches a design that doubles before the first word. Stripes that omit the first flag, or that restart in the middle, expose accumulators left dirty after a result or a restart flag that is ignored. Idle cycles carrying junk flags, and random stripes of 1 to 14 data disks, catch idle beats that leak into the sums and outputs that drift or pulse at the wrong time.

// File: rtl/pq_pkg.sv
package pq_pkg;
    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  GF_REDUCE = 8'h1D;   // x^8 = x^4+x^3+x^2+1
endpackage

// File: rtl/pq_gf_double.sv
// Multiplies every byte lane by 2 in GF(2^8).
module pq_gf_double #(
    parameter  int LANES = 32,
    localparam int W     = LANES * pq_pkg::BYTE_W
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int BW = pq_pkg::BYTE_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BW-1:0] byte_in;
        logic [BW-1:0] fold;
        assign byte_in = din[l*BW +: BW];
        // sign of the byte selects the reduction constant
        assign fold    = {BW{byte_in[BW-1]}} & pq_pkg::GF_REDUCE;
        assign dout[l*BW +: BW] = {byte_in[BW-2:0], 1'b0} ^ fold;
    end
endmodule

// File: rtl/pq_accum_step.sv
// One Horner step: P' = P ^ D, Q' = 2*Q ^ D. A restart zeroes the old sums.
module pq_accum_step #(
    parameter  int LANES = 32,
    localparam int W     = LANES * pq_pkg::BYTE_W
) (
    input  logic [W-1:0] p_acc,
    input  logic [W-1:0] q_acc,
    input  logic [W-1:0] data,
    input  logic         restart,
    output logic [W-1:0] p_nxt,
    output logic [W-1:0] q_nxt
);
    logic [W-1:0] p_base;
    logic [W-1:0] q_base;
    logic [W-1:0] q_dbl;

    assign p_base = restart ? '0 : p_acc;
    assign q_base = restart ? '0 : q_acc;

    pq_gf_double #(.LANES(LANES)) i_dbl (
        .din  (q_base),
        .dout (q_dbl)
    );

    assign p_nxt = p_base ^ data;
    assign q_nxt = q_dbl  ^ data;
endmodule

// File: rtl/pq_syndrome_gen.sv
module pq_syndrome_gen #(
    parameter  int LANES = 32,
    localparam int W     = LANES * pq_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_first,
    input  logic         in_last,
    output logic         out_valid,
    output logic [W-1:0] out_p,
    output logic [W-1:0] out_q
);
    typedef struct packed {
        logic         rdy;
        logic [W-1:0] p_acc;
        logic [W-1:0] q_acc;
        logic         vld;
        logic [W-1:0] p_res;
        logic [W-1:0] q_res;
    } state_t;

    state_t st_d, st_q;

    logic         beat_ok;
    logic [W-1:0] p_step;
    logic [W-1:0] q_step;

    assign beat_ok = in_valid & st_q.rdy;

    pq_accum_step #(.LANES(LANES)) i_step (
        .p_acc   (st_q.p_acc),
        .q_acc   (st_q.q_acc),
        .data    (in_data),
        .restart (in_first),
        .p_nxt   (p_step),
        .q_nxt   (q_step)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
        st_d.vld = 1'b0;
        if (beat_ok) begin
            if (in_last) begin
                st_d.p_res = p_step;
                st_d.q_res = q_step;
                st_d.vld   = 1'b1;
                st_d.p_acc = '0;
                st_d.q_acc = '0;
            end else begin
                st_d.p_acc = p_step;
                st_d.q_acc = q_step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = st_q.rdy;
    assign out_valid = st_q.vld;
    assign out_p     = st_q.p_res;
    assign out_q     = st_q.q_res;
endmodule

// File: rtl/pq_syndrome_chk.sv
module pq_syndrome_chk #(
    parameter  int LANES = 32,
    localparam int W     = LANES * 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] in_data,
    input logic         in_first,
    input logic         in_last,
    input logic         out_valid,
    input logic [W-1:0] out_p,
    input logic [W-1:0] out_q
);
    // R6
    last_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> out_valid);

    // R6
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready && in_last));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_p) && $stable(out_q)));

    // R7
    single_disk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_first && in_last) |=>
        (out_p == $past(in_data) && out_q == $past(in_data)));

    // R1
    ready_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);
endmodule

bind pq_syndrome_gen pq_syndrome_chk #(.LANES(LANES)) i_pq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_first  (in_first),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_p     (out_p),
    .out_q     (out_q)
);

// File: tb/test_pq_syndrome_gen.sv
module test_pq_syndrome_gen;
    localparam int LANES = 32;
    localparam int W     = LANES * 8;
    typedef logic [W-1:0] word_t;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    logic  in_valid = 1'b0;
    logic  in_first = 1'b0;
    logic  in_last = 1'b0;
    word_t in_data = '0;
    logic  in_ready, out_valid;
    word_t out_p, out_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pq_syndrome_gen #(.LANES(LANES)) i_pq_syndrome_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_p(out_p), .out_q(out_q)
    );

    task automatic check_w(input string req, input word_t act, input word_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_b(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            logic top;
            if (b[i]) r ^= x;
            top = x[7];
            x = {x[6:0], 1'b0};
            if (top) x ^= 8'h1D;
        end
        return r;
    endfunction

    function automatic logic [7:0] gpow(input int z);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < z; i++) r = gmul(r, 8'h02);
        return r;
    endfunction

    function automatic word_t ref_p(input word_t ws[$]);
        word_t r = '0;
        foreach (ws[i]) r ^= ws[i];
        return r;
    endfunction

    function automatic word_t ref_q(input word_t ws[$]);
        word_t r = '0;
        int n = ws.size();
        for (int i = 0; i < n; i++) begin
            logic [7:0] c = gpow(n - 1 - i);
            for (int l = 0; l < LANES; l++)
                r[l*8 +: 8] ^= gmul(c, ws[i][l*8 +: 8]);
        end
        return r;
    endfunction

    function automatic word_t rand_word();
        word_t r;
        for (int k = 0; k < W/32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    // ---------------- per-clock model, compared every cycle ----------------
    word_t m_list[$];
    logic  m_valid = 1'b0;
    logic  m_ready = 1'b0;
    word_t m_p = '0;
    word_t m_q = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            check_b("R1 reset out_valid", out_valid, 1'b0);
            check_b("R1 reset in_ready", in_ready, 1'b0);
            check_w("R1 reset out_p", out_p, '0);
            check_w("R1 reset out_q", out_q, '0);
            m_list.delete();
            m_valid = 1'b0; m_ready = 1'b0; m_p = '0; m_q = '0;
        end else begin
            check_b("R1 in_ready", in_ready, m_ready);
            check_b("R6 out_valid", out_valid, m_valid);
            check_w("R2 out_p", out_p, m_p);
            check_w("R3 out_q", out_q, m_q);
            m_valid = 1'b0;
            if (in_valid && in_ready) begin
                if (in_first) m_list.delete();
                m_list.push_back(in_data);
                if (in_last) begin
                    m_p = ref_p(m_list);
                    m_q = ref_q(m_list);
                    m_valid = 1'b1;
                    m_list.delete();
                end
            end
            m_ready = 1'b1;
        end
    end

    // ---------------- drivers (inputs change 2 ns after posedge) ----------------
    task automatic drive_beat(input word_t d, input logic f, input logic l);
        in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #2;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0; in_data = rand_word(); in_first = 1'b1; in_last = 1'b1;
            @(negedge clk);
            check_b("R10 no output on idle", out_valid, 1'b0);
            @(posedge clk); #2;
        end
        in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic run_stripe(input word_t ws[$], input bit use_first,
                              output word_t p, output word_t q);
        for (int i = 0; i < ws.size(); i++)
            drive_beat(ws[i], use_first && (i == 0), i == ws.size() - 1);
        @(negedge clk);
        check_b("R6 valid after last", out_valid, 1'b1);
        p = out_p; q = out_q;
        @(posedge clk); #2;
    endtask

    initial begin
        word_t ws[$];
        word_t p, q, e, a, b;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #2;

        // R7: single data disk
        a = rand_word();
        ws = '{a};
        run_stripe(ws, 1'b1, p, q);
        check_w("R7 single P", p, a);
        check_w("R7 single Q", q, a);

        // R4: reduction on top bit set
        ws = '{{LANES{8'h80}}, word_t'(0)};
        run_stripe(ws, 1'b1, p, q);
        check_w("R4 P of 0x80", p, {LANES{8'h80}});
        check_w("R4 Q 0x80 doubled", q, {LANES{8'h1D}});
        ws = '{{LANES{8'h80}}, word_t'(0), word_t'(0)};
        run_stripe(ws, 1'b1, p, q);
        check_w("R4 Q 0x80 times 4", q, {LANES{8'h3A}});

        // R5: alternating lanes
        for (int l = 0; l < LANES; l++) begin
            a[l*8 +: 8] = (l % 2 == 0) ? 8'h80 : 8'h40;
            e[l*8 +: 8] = (l % 2 == 0) ? 8'h1D : 8'h80;
        end
        ws = '{a, word_t'(0)};
        run_stripe(ws, 1'b1, p, q);
        check_w("R5 lane independence Q", q, e);

        // R8: stripe with no first flag after a result
        ws = '{rand_word(), rand_word(), rand_word()};
        run_stripe(ws, 1'b0, p, q);
        check_w("R8 no-first P", p, ref_p(ws));
        check_w("R8 no-first Q", q, ref_q(ws));

        // R9: restart in the middle
        a = rand_word(); b = rand_word();
        drive_beat(rand_word(), 1'b1, 1'b0);
        drive_beat(rand_word(), 1'b0, 1'b0);
        drive_beat(a, 1'b1, 1'b0);
        drive_beat(b, 1'b0, 1'b1);
        @(negedge clk);
        ws = '{a, b};
        check_w("R9 restart P", out_p, ref_p(ws));
        check_w("R9 restart Q", out_q, ref_q(ws));
        @(posedge clk); #2;

        // R10: idle gaps with junk
        a = rand_word(); b = rand_word();
        drive_beat(a, 1'b1, 1'b0);
        idle(3);
        drive_beat(b, 1'b0, 1'b1);
        @(negedge clk);
        ws = '{a, b};
        check_w("R10 gaps P", out_p, ref_p(ws));
        check_w("R10 gaps Q", out_q, ref_q(ws));
        p = out_p; q = out_q;
        @(posedge clk); #2;

        // R11: outputs hold
        idle(5);
        @(negedge clk);
        check_w("R11 hold P", out_p, p);
        check_w("R11 hold Q", out_q, q);
        @(posedge clk); #2;

        // R2/R3: random stripes, 3..16 total disks
        for (int s = 0; s < 40; s++) begin
            int nd = 1 + ($urandom % 14);
            ws.delete();
            for (int i = 0; i < nd; i++) ws.push_back(rand_word());
            run_stripe(ws, 1'b1, p, q);
            check_w("R2 random P", p, ref_p(ws));
            check_w("R3 random Q", q, ref_q(ws));
            if (s % 3 == 0) idle(1);
        end

        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule